// File: doc/BRIEF.md
# Task Register Load Sequencer

This block performs the privileged operation that installs the current task's state-segment descriptor into the task register. It is given a 16-bit segment selector, the processor's mode and privilege, and the location and limit of the global descriptor table. It then works through a fixed series of architectural checks. Any check that fails ends the operation with a single fault report: a vector plus an error code.

When the selector passes the front checks, the sequencer reads the descriptor through a simple word-wide memory port. It holds a bus lock from the first read until the write that marks the descriptor busy. It then captures the selector, the assembled base and the raw 20-bit limit into the task register. In long mode it reads a 16-byte descriptor, so the base is 64 bits wide. In all other modes it reads 8 bytes.

The memory port returns read data one clock after a read request, and it accepts a write in the cycle `mem_we` is high. Addresses are byte addresses, and each word is 32 bits. Whatever the operand size, the selector input is always 16 bits wide, in long mode as well.

Top module: `trl_load_seq`

## Requirements
- R1: A request made outside protected mode (`prot_mode`=0), or with `cpl` other than 0, produces a fault with vector 13 and error code 0, and issues no memory access.
- R2: A selector whose bits 15:2 are all zero is null. Whatever bits 1:0 hold, it produces fault vector 13 with code 0 and issues no memory access.
- R3: The selector holds the index in bits 15:3, the table flag in bit 2 and the requested privilege in bits 1:0. A table flag of 1 is a fault. So is a last descriptor byte (index×8+7, or index×8+15 in long mode) greater than `gdt_limit`. Either one gives vector 13 with the full selector as code and no memory access.
- R4: Descriptor bits 44:40 (word 1, bits 12:8) must equal 5'b00001 or 5'b01001. Any other value gives vector 13 with the selector as code, and this check takes priority over the present check.
- R5: If the descriptor's present bit 47 (word 1, bit 15) is clear, the fault is vector 11 with the selector as code.
- R6: On success the block writes word 1 back exactly once, with bit 9 (descriptor bit 41) set and every other bit unchanged. `mem_lock` stays high on every cycle from the first read through that write.
- R7: On success `done` pulses for one cycle. In the same cycle `tr_sel` shows the selector, `tr_limit` shows {word1[19:16], word0[15:0]}, and `tr_base[31:0]` shows {word1[31:24], word1[7:0], word0[31:16]}.
- R8: In long mode the block reads four words and `tr_base[63:32]` is word 2. Outside long mode it reads two words and `tr_base[63:32]` is zero.
- R9: A fault is a one-cycle `fault` strobe. It leaves the task register outputs and memory unchanged, and `done` and `fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a load, sampled while idle |
| sel | input | 16 | Segment selector operand |
| prot_mode | input | 1 | Processor is in protected mode |
| cpl | input | 2 | Current privilege level |
| long_mode | input | 1 | 64-bit mode, 16-byte descriptor |
| gdt_base | input | ADDR_W | Byte address of the global table |
| gdt_limit | input | LIMIT_W | Global table limit in bytes |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_lock | output | 1 | Locked read-modify-write in progress |
| mem_addr | output | ADDR_W | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success strobe |
| fault | output | 1 | One-cycle fault strobe |
| fault_vec | output | 8 | Fault vector (13 or 11) |
| fault_code | output | 16 | Fault error code |
| tr_sel | output | 16 | Task register selector |
| tr_base | output | 64 | Task register base |
| tr_limit | output | 20 | Task register limit |

## Verification
A wrong state or word counter in this block becomes visible within a few cycles of the request. The read count differs from two or four, or the lock drops before the write-back, or the outcome strobe comes too early or late. Corrupted captured descriptor words surface at the same `done` strobe as a wrong base or limit, or as the wrong fault vector. A wrong order among the checks shows up at once as a wrong vector or code, or as memory traffic that should not be there. After the write-back, the stored word 1 reveals a bad busy update.

// File: rtl/trl_pkg.sv
package trl_pkg;
   localparam logic [7:0] VEC_GP = 8'd13;
   localparam logic [7:0] VEC_NP = 8'd11;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WAIT,
      ST_CHECK,
      ST_WRITE
   } trl_state_e;

   typedef struct packed {
      logic        fault;
      logic [7:0]  vec;
      logic [15:0] code;
   } trl_verdict_t;
endpackage

// File: rtl/trl_front_check.sv
module trl_front_check #(
   parameter int LIMIT_W = 16
) (
   input  logic [15:0]          sel,
   input  logic                 prot_mode,
   input  logic [1:0]           cpl,
   input  logic                 long_mode,
   input  logic [LIMIT_W-1:0]   gdt_limit,
   output trl_pkg::trl_verdict_t verdict
);
   import trl_pkg::*;

   localparam int SUM_W = 33;

   logic [SUM_W-1:0] last_byte;
   logic [SUM_W-1:0] limit_ext;

   assign last_byte = SUM_W'({sel[15:3], 3'b000}) + (long_mode ? SUM_W'(15) : SUM_W'(7));
   assign limit_ext = SUM_W'(gdt_limit);

   always_comb begin
      verdict = '0;
      if (!prot_mode || cpl != 2'd0) begin
         verdict.fault = 1'b1;
         verdict.vec   = VEC_GP;
      end else if (sel[15:2] == 14'd0) begin
         verdict.fault = 1'b1;
         verdict.vec   = VEC_GP;
      end else if (sel[2] || (last_byte > limit_ext)) begin
         verdict.fault = 1'b1;
         verdict.vec   = VEC_GP;
         verdict.code  = sel;
      end
   end
endmodule

// File: rtl/trl_desc_eval.sv
module trl_desc_eval #(
   parameter bit LONG_EN = 1'b1
) (
   input  logic [2:0][31:0]      words,
   input  logic [15:0]           sel,
   input  logic                  long_sel,
   output trl_pkg::trl_verdict_t verdict,
   output logic [63:0]           base,
   output logic [19:0]           limit
);
   import trl_pkg::*;

   logic [4:0] sys_type;
   logic       type_ok;
   logic       present;
   logic       unused_attr;

   assign sys_type    = words[1][12:8];
   assign present     = words[1][15];
   assign type_ok     = (sys_type == 5'b00001) || (sys_type == 5'b01001);
   assign unused_attr = ^{words[1][23:20], words[1][14:13]};

   assign base[31:0] = {words[1][31:24], words[1][7:0], words[0][31:16]};
   assign limit      = {words[1][19:16], words[0][15:0]};

   generate
      if (LONG_EN) begin : g_wide_base
         assign base[63:32] = long_sel ? words[2] : 32'd0;
      end else begin : g_narrow_base
         logic unused_hi;
         logic unused_lm;
         assign unused_hi   = ^words[2];
         assign unused_lm   = long_sel;
         assign base[63:32] = 32'd0;
      end
   endgenerate

   always_comb begin
      verdict = '0;
      if (!type_ok) begin
         verdict.fault = 1'b1;
         verdict.vec   = VEC_GP;
         verdict.code  = sel;
      end else if (!present) begin
         verdict.fault = 1'b1;
         verdict.vec   = VEC_NP;
         verdict.code  = sel;
      end
   end
endmodule

// File: rtl/trl_load_seq.sv
module trl_load_seq #(
   parameter int ADDR_W  = 32,
   parameter int LIMIT_W = 16,
   parameter bit LONG_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [15:0]        sel,
   input  logic               prot_mode,
   input  logic [1:0]         cpl,
   input  logic               long_mode,
   input  logic [ADDR_W-1:0]  gdt_base,
   input  logic [LIMIT_W-1:0] gdt_limit,
   output logic               mem_req,
   output logic               mem_we,
   output logic               mem_lock,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [31:0]        mem_wdata,
   input  logic [31:0]        mem_rdata,
   output logic               busy,
   output logic               done,
   output logic               fault,
   output logic [7:0]         fault_vec,
   output logic [15:0]        fault_code,
   output logic [15:0]        tr_sel,
   output logic [63:0]        tr_base,
   output logic [19:0]        tr_limit
);
   import trl_pkg::*;

   localparam logic [1:0] LAST_NARROW = 2'd1;
   localparam logic [1:0] LAST_WIDE   = 2'd3;
   localparam logic [31:0] BUSY_MASK  = 32'h0000_0200;

   generate
      if (ADDR_W < 17) begin : g_bad_addr
         $error("trl_load_seq: ADDR_W must cover a 64 KiB table");
      end
      if (LIMIT_W < 16 || LIMIT_W > 32) begin : g_bad_limit
         $error("trl_load_seq: LIMIT_W must lie in 16..32");
      end
   endgenerate

   trl_state_e       state;
   logic [1:0]       idx;
   logic [1:0]       pend_idx;
   logic             pend;
   logic [15:0]      sel_q;
   logic             lm_q;
   logic [2:0][31:0] desc_q;
   logic             lm_eff;
   logic [1:0]       last_idx;
   trl_verdict_t     front_v;
   trl_verdict_t     desc_v;
   logic [63:0]      eval_base;
   logic [19:0]      eval_limit;
   logic [ADDR_W-1:0] desc_addr;

   assign lm_eff   = long_mode & LONG_EN;
   assign last_idx = lm_q ? LAST_WIDE : LAST_NARROW;

   trl_front_check #(.LIMIT_W(LIMIT_W)) front_i (
      .sel       (sel),
      .prot_mode (prot_mode),
      .cpl       (cpl),
      .long_mode (lm_eff),
      .gdt_limit (gdt_limit),
      .verdict   (front_v)
   );

   trl_desc_eval #(.LONG_EN(LONG_EN)) eval_i (
      .words    (desc_q),
      .sel      (sel_q),
      .long_sel (lm_q),
      .verdict  (desc_v),
      .base     (eval_base),
      .limit    (eval_limit)
   );

   assign desc_addr = gdt_base + ADDR_W'({sel_q[15:3], 3'b000});

   always_comb begin
      mem_addr = desc_addr;
      if (state == ST_READ)  mem_addr = desc_addr + ADDR_W'({idx, 2'b00});
      if (state == ST_WRITE) mem_addr = desc_addr + ADDR_W'(4);
   end

   assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
   assign mem_we    = (state == ST_WRITE);
   assign mem_lock  = (state != ST_IDLE);
   assign mem_wdata = desc_q[1] | BUSY_MASK;
   assign busy      = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         idx        <= '0;
         pend       <= 1'b0;
         pend_idx   <= '0;
         sel_q      <= '0;
         lm_q       <= 1'b0;
         desc_q     <= '0;
         done       <= 1'b0;
         fault      <= 1'b0;
         fault_vec  <= '0;
         fault_code <= '0;
         tr_sel     <= '0;
         tr_base    <= '0;
         tr_limit   <= '0;
      end else begin
         done     <= 1'b0;
         fault    <= 1'b0;
         pend     <= (state == ST_READ);
         pend_idx <= idx;
         if (pend) begin
            case (pend_idx)
               2'd0:    desc_q[0] <= mem_rdata;
               2'd1:    desc_q[1] <= mem_rdata;
               2'd2:    desc_q[2] <= mem_rdata;
               default: ;
            endcase
         end
         case (state)
            ST_IDLE: begin
               if (req) begin
                  sel_q <= sel;
                  lm_q  <= lm_eff;
                  idx   <= '0;
                  if (front_v.fault) begin
                     fault      <= 1'b1;
                     fault_vec  <= front_v.vec;
                     fault_code <= front_v.code;
                  end else begin
                     state <= ST_READ;
                  end
               end
            end
            ST_READ: begin
               idx <= idx + 2'd1;
               if (idx == last_idx) state <= ST_WAIT;
            end
            ST_WAIT: state <= ST_CHECK;
            ST_CHECK: begin
               if (desc_v.fault) begin
                  fault      <= 1'b1;
                  fault_vec  <= desc_v.vec;
                  fault_code <= desc_v.code;
                  state      <= ST_IDLE;
               end else begin
                  state <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               tr_sel   <= sel_q;
               tr_base  <= eval_base;
               tr_limit <= eval_limit;
               done     <= 1'b1;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/trl_load_seq_chk.sv
module trl_load_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        done,
   input logic        fault,
   input logic [7:0]  fault_vec,
   input logic [15:0] fault_code,
   input logic        mem_req,
   input logic        mem_we,
   input logic        mem_lock,
   input logic [15:0] tr_sel,
   input logic [63:0] tr_base
);
   p_no_idle_traffic_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !mem_lock));

   p_np_global_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && fault_vec == 8'd11) |-> (fault_code[2] == 1'b0 && fault_code[15:3] != 13'd0));

   p_write_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_lock);

   p_write_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> done);

   p_tr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(tr_sel) && $stable(tr_base)));

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   p_vec_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (fault_vec == 8'd13 || fault_vec == 8'd11));
endmodule

bind trl_load_seq trl_load_seq_chk chk_i (.*);

// File: tb/trl_load_seq_tb.sv
module trl_load_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [15:0] sel = '0;
   logic        prot_mode = 1'b0;
   logic [1:0]  cpl = '0;
   logic        long_mode = 1'b0;
   logic [31:0] gdt_base = 32'h100;
   logic [15:0] gdt_limit = 16'hFFFF;
   logic        mem_req, mem_we, mem_lock;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        busy, done, fault;
   logic [7:0]  fault_vec;
   logic [15:0] fault_code, tr_sel;
   logic [63:0] tr_base;
   logic [19:0] tr_limit;

   logic [31:0] mem [0:511];
   int total = 0;
   int bad = 0;
   int rd_cnt = 0;
   int lock_err = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   trl_load_seq dut_i (.*);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req && !mem_we) begin
         rd_cnt    <= rd_cnt + 1;
         mem_rdata <= mem[mem_addr[10:2]];
      end
      if (mem_req && mem_we) mem[mem_addr[10:2]] <= mem_wdata;
      if (mem_req && !mem_lock) lock_err <= lock_err + 1;
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         bad   = bad + 1;
         total = total + 1;
         $display("FAIL watchdog expired: actual=%0d expected<150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put_desc(input int ix, input logic [4:0] typ, input bit p);
      int w = 64 + ix * 2;
      @(negedge clk);
      mem[w]     = {16'(32'h1357 * (ix + 1)), 16'(32'h0F0F + ix * 17)};
      mem[w + 1] = {8'(32'hC0 + ix), 4'h4, 4'(ix), p, 2'b00, typ, 8'(ix * 7)};
      mem[w + 2] = 32'hA500_0000 + 32'(ix);
      mem[w + 3] = 32'h0;
   endtask

   task automatic run_case(input logic [15:0] s, input bit pm, input logic [1:0] c,
                           input bit lm, input logic [15:0] lim);
      bit          e_fault;
      logic [7:0]  e_vec;
      logic [15:0] e_code;
      int          e_rd;
      int          w;
      int          n;
      int          rd0;
      int          lk0;
      logic [31:0] w0, w1, w2;
      logic [15:0] sel_b;
      logic [63:0] base_b, e_base;
      logic [19:0] lim_b, e_lim;
      w  = 64 + int'(s[15:3]) * 2;
      w0 = (w + 2 < 512) ? mem[w] : 32'h0;
      w1 = (w + 2 < 512) ? mem[w + 1] : 32'h0;
      w2 = (w + 2 < 512) ? mem[w + 2] : 32'h0;
      e_fault = 1'b1; e_vec = 8'd13; e_code = 16'h0; e_rd = 0;
      if (!pm || c != 2'd0) e_code = 16'h0;
      else if (s[15:2] == 14'd0) e_code = 16'h0;
      else if (s[2] || (int'(s[15:3]) * 8 + (lm ? 15 : 7) > int'(lim))) e_code = s;
      else begin
         e_rd = lm ? 4 : 2;
         e_code = s;
         if (!(w1[12:8] == 5'b00001 || w1[12:8] == 5'b01001)) e_vec = 8'd13;
         else if (!w1[15]) e_vec = 8'd11;
         else e_fault = 1'b0;
      end
      e_base = {(lm ? w2 : 32'h0), w1[31:24], w1[7:0], w0[31:16]};
      e_lim  = {w1[19:16], w0[15:0]};
      sel_b = tr_sel; base_b = tr_base; lim_b = tr_limit;
      @(negedge clk);
      sel = s; prot_mode = pm; cpl = c; long_mode = lm; gdt_limit = lim; req = 1'b1;
      rd0 = rd_cnt; lk0 = lock_err;
      @(negedge clk);
      req = 1'b0;
      n = 0;
      while (!(done || fault) && n < 60) begin
         @(negedge clk);
         n++;
      end
      chk(fault == e_fault && done == !e_fault, "R9 outcome strobe", {done, fault}, {!e_fault, e_fault});
      chk(rd_cnt - rd0 == e_rd, (e_rd == 0) ? "R1/R2/R3 no memory access" : "R8 word reads",
          rd_cnt - rd0, e_rd);
      chk(lock_err == lk0, "R6 lock held over access", lock_err - lk0, 0);
      if (e_fault) begin
         chk(fault_vec == e_vec, (e_vec == 8'd11) ? "R5 vector" : "R4/R3 vector", fault_vec, e_vec);
         chk(fault_code == e_code, "R3/R4/R5 code", fault_code, e_code);
         chk(tr_sel == sel_b && tr_base == base_b && tr_limit == lim_b, "R9 task register kept",
             tr_sel, sel_b);
         if (w + 2 < 512) chk(mem[w + 1] == w1, "R9 memory kept", mem[w + 1], w1);
      end else begin
         chk(tr_sel == s, "R7 selector", tr_sel, s);
         chk(tr_base == e_base, "R7/R8 base", tr_base, e_base);
         chk(tr_limit == e_lim, "R7 limit", tr_limit, e_lim);
         chk(mem[w + 1] == (w1 | 32'h200) && mem[w] == w0, "R6 busy bit write", mem[w + 1], w1 | 32'h200);
      end
      @(negedge clk);
      chk(!done && !fault, "R9 one-cycle strobe", {done, fault}, 0);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) mem[i] = 32'h0;
      repeat (3) @(negedge clk);
      chk(!done && !fault && !busy && !mem_req && tr_sel == 16'h0 && tr_base == 64'h0,
          "R9 reset state", {done, fault, busy, mem_req}, 0);
      rst_n = 1'b1;

      // R1: mode and privilege sweep
      for (int pm = 0; pm < 2; pm++)
         for (int c = 0; c < 4; c++) begin
            put_desc(3, 5'b01001, 1'b1);
            run_case(16'(3 << 3), pm[0], c[1:0], 1'b0, 16'hFFFF);
         end

      // R2: null selectors, RPL ignored; TI=1 with index 0 is not null (R3)
      for (int r = 0; r < 4; r++) run_case(16'(r), 1'b1, 2'd0, 1'b0, 16'hFFFF);
      run_case(16'h0004, 1'b1, 2'd0, 1'b0, 16'hFFFF);
      put_desc(5, 5'b00001, 1'b1);
      run_case(16'h002C, 1'b1, 2'd0, 1'b0, 16'hFFFF);

      // R3 and R8: limit boundaries, narrow and long
      for (int i = 1; i < 7; i++)
         for (int lm = 0; lm < 2; lm++) begin
            put_desc(i, 5'b01001, 1'b1);
            run_case(16'(i << 3), 1'b1, 2'd0, lm[0], 16'(i * 8 + (lm ? 14 : 6)));
            run_case(16'((i << 3) | 1), 1'b1, 2'd0, lm[0], 16'(i * 8 + (lm ? 15 : 7)));
         end

      // R4, R5, R6, R7, R8: type and present sweep
      for (int t = 0; t < 32; t++)
         for (int p = 0; p < 2; p++)
            for (int lm = 0; lm < 2; lm++) begin
               int ix = 1 + (t % 20);
               put_desc(ix, 5'(t), p[0]);
               run_case(16'((ix << 3) | (t & 3)), 1'b1, 2'd0, lm[0], 16'hFFFF);
            end

      // R4: reload of a descriptor already marked busy faults
      put_desc(8, 5'b00001, 1'b1);
      run_case(16'(8 << 3), 1'b1, 2'd0, 1'b0, 16'hFFFF);
      run_case(16'(8 << 3), 1'b1, 2'd0, 1'b0, 16'hFFFF);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule